// File: doc/BRIEF.md
# Clock Source Selector with Warmup

This block decides which oscillator times the system clock and how far that clock is divided. Two oscillators are modelled as tick strobes: a high-frequency path and a ring oscillator. Both strobes are sampled on one reference clock. The block emits a clock-enable pulse train. Each pulse marks one system-clock period, and the period is the programmed number of ticks of the active source. A status output tells software which source is actually driving the clock.

Switching to the ring oscillator takes effect at once. Switching back to the high-frequency path does not: the ring oscillator stays in charge until a programmable number of high-frequency ticks has been counted. The source-select bit is kept through every reset except power-on. A stop-mode flag silences the enable train. A stop-exit request releases it again, but only after a warmup on the selected source: a short ring warmup, or the full high-frequency warmup. An oscillator-off bit is also provided, so that an external clock can be fed in on the high-frequency input.

Top module: `clk_src_sel`

## Requirements
- R1: `cfg_div` selects the number of active-source ticks per `clk_en` pulse: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and any code with bit 2 set gives 256.
- R2: A new `cfg_div` value is applied only when the divide counter reaches its terminal count. The enable period in progress when the write lands keeps its old length.
- R3: Writing `cfg_ring_sel`=1 sets `sel_ring` at the write edge and `ring_active` one edge later. From then on `clk_en` is paced by `ring_tick`.
- R4: Writing `cfg_ring_sel`=0 while the ring oscillator is active keeps `ring_active` at 1, and keeps `clk_en` paced by `ring_tick`, until HF_WARM_TICKS high-frequency ticks have been counted. `ring_active` falls on the edge after the last of those ticks.
- R5: `sel_ring` is cleared only by `por_n`. A `rst_n` reset clears `div_code` and `hf_osc_off` but keeps `sel_ring`, and it leaves `ring_active` at 1 when `sel_ring` is 1.
- R6: While `stop_mode` is 1, `clk_en` is 0. This holds in the cycle where `stop_mode` first rises, even if a pulse was due in that cycle.
- R7: After a `stop_exit` request, `clk_en` stays 0 during a warmup on the selected source: RING_WARM_TICKS ring ticks with `ring_active`=1 when `sel_ring` is 1, or HF_WARM_TICKS high-frequency ticks with `ring_active`=0 when `sel_ring` is 0. The first pulse then falls on the next tick of that source.
- R8: Stop mode entered during an exit warmup discards the ticks already counted. The next exit performs the full warmup again.
- R9: `hf_osc_off` reads 0 after any reset and follows the `cfg_hf_off` bit written through the configuration port.
- R10: `clk_en` is only ever 1 in a cycle where the tick strobe of the source reported by `ring_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples all strobes |
| por_n | input | 1 | Synchronous active-low power-on reset; clears every register |
| rst_n | input | 1 | Synchronous active-low system reset; keeps the source-select bit |
| hf_tick | input | 1 | One-cycle strobe per high-frequency oscillator period |
| ring_tick | input | 1 | One-cycle strobe per ring oscillator period |
| cfg_we | input | 1 | Writes all configuration fields in this cycle |
| cfg_ring_sel | input | 1 | Source-select value to write (1 = ring) |
| cfg_div | input | 3 | Divider code to write |
| cfg_hf_off | input | 1 | High-frequency oscillator disable value to write |
| stop_mode | input | 1 | Stop-mode flag from the processor |
| stop_exit | input | 1 | Request to leave stop mode |
| clk_en | output | 1 | System clock-enable pulse |
| ring_active | output | 1 | 1 while the ring oscillator drives the system clock |
| sel_ring | output | 1 | Read-back of the source-select bit |
| div_code | output | 3 | Read-back of the divider code |
| hf_osc_off | output | 1 | Disable to the high-frequency oscillator |

## Verification
Stop entry and a due enable pulse can fall in the same cycle. With the divider at 1 and a high-frequency tick every cycle, a pulse is due in every cycle, so the bench raises `stop_mode` in one of them and requires `clk_en` low in that very cycle. A divider write can also coincide with an enable period already in progress. The bench lands the write a few cycles after a pulse and requires the old eight-tick gap to finish before single-tick pulses begin.

// File: rtl/clk_src_pkg.sv
// Shared types and helpers for the clock source selector.
// Assumes: divider codes are 3 bits wide and the longest ratio is 256.
package clk_src_pkg;

    localparam int DIV_W  = 3;
    localparam int TERM_W = 8;

    typedef enum logic [2:0] {
        ST_HF        = 3'd0,  // high-frequency source drives clock
        ST_RING      = 3'd1,  // ring oscillator drives clock
        ST_HF_WARM   = 3'd2,  // ring drives while high-frequency warms up
        ST_STOP      = 3'd3,  // stop mode, no enables
        ST_EXIT_RING = 3'd4,  // stop exit, ring warmup, enables held
        ST_EXIT_HF   = 3'd5   // stop exit, high-frequency warmup, enables held
    } src_state_t;

    // Terminal count of the divide counter for a divider code.
    function automatic logic [TERM_W-1:0] div_term(input logic [DIV_W-1:0] code);
        logic [TERM_W-1:0] t;
        if (code[2]) begin
            t = 8'd255;
        end else begin
            case (code[1:0])
                2'b00:   t = 8'd0;
                2'b01:   t = 8'd1;
                2'b10:   t = 8'd3;
                default: t = 8'd7;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/cs_warm_timer.sv
// Counts oscillator tick strobes during a warmup window.
// Assumes: len is at least 1; clr is raised on the cycle a window starts
// so that every window begins from zero.
module cs_warm_timer #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             srst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             done
);

    logic [LEN_W-1:0] cnt_q;

    // Done on the tick that completes the window.
    assign done = en && tick && (cnt_q == len - LEN_W'(1));

    // Advance on each counted tick, restart on clear.
    always_ff @(posedge clk) begin
        if (!srst_n || clr) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    a_r8_cnt_below_len: assert property (@(posedge clk) disable iff (!srst_n)
        en |-> (cnt_q < len))
        else $error("warmup counter passed its length");

endmodule

// File: rtl/cs_src_fsm.sv
// Tracks which source drives the clock, the warmups and stop mode.
// Assumes: stop_exit is a request honoured only while stopped; the caller
// supplies boot_ring = select bit already qualified by power-on reset.
module cs_src_fsm
    import clk_src_pkg::*;
#(
    parameter int HF_WARM_TICKS   = 65536,
    parameter int RING_WARM_TICKS = 10
) (
    input  logic clk,
    input  logic srst_n,
    input  logic boot_ring,
    input  logic sel,
    input  logic hf_tick,
    input  logic ring_tick,
    input  logic stop_mode,
    input  logic stop_exit,
    output logic ring_active,
    output logic run,
    output logic restart,
    output logic exit_hold
);

    localparam int MAX_WARM = (HF_WARM_TICKS > RING_WARM_TICKS) ? HF_WARM_TICKS : RING_WARM_TICKS;
    localparam int LEN_W    = $clog2(MAX_WARM + 1);

    src_state_t st_q, st_d;
    logic       ring_q, ring_d;
    logic       warm_en, warm_hf, warm_tick, warm_done;
    logic [LEN_W-1:0] warm_len;

    // Pick which oscillator the current warmup counts.
    always_comb begin
        warm_en   = (st_q == ST_HF_WARM) || (st_q == ST_EXIT_RING) || (st_q == ST_EXIT_HF);
        warm_hf   = (st_q == ST_HF_WARM) || (st_q == ST_EXIT_HF);
        warm_tick = warm_hf ? hf_tick : ring_tick;
        warm_len  = warm_hf ? LEN_W'(HF_WARM_TICKS) : LEN_W'(RING_WARM_TICKS);
    end

    cs_warm_timer #(.LEN_W(LEN_W)) u_warm (
        .clk    (clk),
        .srst_n (srst_n),
        .clr    (restart),
        .en     (warm_en),
        .tick   (warm_tick),
        .len    (warm_len),
        .done   (warm_done)
    );

    // Next-state selection; stop entry overrides every running state.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_HF:        if (sel) st_d = ST_RING;
            ST_RING:      if (!sel) st_d = ST_HF_WARM;
            ST_HF_WARM:   if (sel) st_d = ST_RING;
                          else if (warm_done) st_d = ST_HF;
            ST_STOP:      if (stop_exit) st_d = sel ? ST_EXIT_RING : ST_EXIT_HF;
            ST_EXIT_RING: if (warm_done) st_d = ST_RING;
            ST_EXIT_HF:   if (warm_done) st_d = ST_HF;
            default:      st_d = ST_HF;
        endcase
        if (st_q != ST_STOP && stop_mode) begin
            st_d = ST_STOP;
        end
    end

    // Status follows the source that will drive after this edge.
    always_comb begin
        case (st_d)
            ST_RING, ST_HF_WARM, ST_EXIT_RING: ring_d = 1'b1;
            ST_STOP:                           ring_d = ring_q;
            default:                           ring_d = 1'b0;
        endcase
    end

    // State and status registers; a reset restores the selected source.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            st_q   <= boot_ring ? ST_RING : ST_HF;
            ring_q <= boot_ring;
        end else begin
            st_q   <= st_d;
            ring_q <= ring_d;
        end
    end

    assign ring_active = ring_q;
    assign restart     = (st_d != st_q);
    assign run         = (st_q == ST_HF) || (st_q == ST_RING) || (st_q == ST_HF_WARM);
    assign exit_hold   = (st_q == ST_EXIT_RING) || (st_q == ST_EXIT_HF);

    a_r4_status_lags_clear: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q == ST_RING && !sel && !stop_mode) |=> ring_active)
        else $error("status dropped before high-frequency warmup");

    a_r7_ring_exit_status: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q == ST_EXIT_RING) |-> ring_active)
        else $error("ring exit warmup without ring status");

    a_r7_hf_exit_status: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q == ST_EXIT_HF) |-> !ring_active)
        else $error("high-frequency exit warmup with ring status");

    a_r6_stop_no_run: assert property (@(posedge clk) disable iff (!srst_n)
        (st_q == ST_STOP) |-> !run)
        else $error("running while stopped");

endmodule

// File: rtl/cs_clk_div.sv
// Divides the active source's ticks into clock-enable pulses.
// Assumes: restart is raised on every source or run change; the divider
// code is sampled only at terminal count or restart.
module cs_clk_div
    import clk_src_pkg::*;
(
    input  logic             clk,
    input  logic             srst_n,
    input  logic             run,
    input  logic             hold,
    input  logic             restart,
    input  logic             tick,
    input  logic [DIV_W-1:0] code,
    output logic             clk_en
);

    logic [TERM_W-1:0] cnt_q;
    logic [TERM_W-1:0] term_q;
    logic              at_term;

    assign at_term = (cnt_q == term_q);
    assign clk_en  = run && !hold && tick && at_term;

    // Count active ticks; reload the ratio only at terminal count.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            cnt_q  <= '0;
            term_q <= div_term('0);
        end else if (restart || !run) begin
            cnt_q  <= '0;
            term_q <= div_term(code);
        end else if (tick && !hold) begin
            if (at_term) begin
                cnt_q  <= '0;
                term_q <= div_term(code);
            end else begin
                cnt_q  <= cnt_q + TERM_W'(1);
            end
        end
    end

    a_r2_cnt_within_term: assert property (@(posedge clk) disable iff (!srst_n)
        cnt_q <= term_q)
        else $error("divide counter beyond terminal count");

    a_r1_pulse_restarts: assert property (@(posedge clk) disable iff (!srst_n)
        clk_en |=> (cnt_q == '0))
        else $error("counter not restarted after pulse");

endmodule

// File: rtl/clk_src_sel.sv
// Top of the clock source selector: configuration fields, source FSM and
// divider. Assumes: both tick strobes are synchronous to clk; por_n is a
// superset of rst_n.
module clk_src_sel
    import clk_src_pkg::*;
#(
    parameter int HF_WARM_TICKS   = 65536,
    parameter int RING_WARM_TICKS = 10
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             hf_tick,
    input  logic             ring_tick,
    input  logic             cfg_we,
    input  logic             cfg_ring_sel,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_hf_off,
    input  logic             stop_mode,
    input  logic             stop_exit,
    output logic             clk_en,
    output logic             ring_active,
    output logic             sel_ring,
    output logic [DIV_W-1:0] div_code,
    output logic             hf_osc_off
);

    logic             srst_n;
    logic             sel_q;
    logic [DIV_W-1:0] div_q;
    logic             hf_off_q;
    logic             run, restart, exit_hold, src_tick;

    assign srst_n = por_n && rst_n;

    // Source-select bit: only power-on reset clears it.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            sel_q <= 1'b0;
        end else if (rst_n && cfg_we) begin
            sel_q <= cfg_ring_sel;
        end
    end

    // Divider code and oscillator disable: cleared by any reset.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            div_q    <= '0;
            hf_off_q <= 1'b0;
        end else if (cfg_we) begin
            div_q    <= cfg_div;
            hf_off_q <= cfg_hf_off;
        end
    end

    cs_src_fsm #(
        .HF_WARM_TICKS   (HF_WARM_TICKS),
        .RING_WARM_TICKS (RING_WARM_TICKS)
    ) u_fsm (
        .clk         (clk),
        .srst_n      (srst_n),
        .boot_ring   (por_n && sel_q),
        .sel         (sel_q),
        .hf_tick     (hf_tick),
        .ring_tick   (ring_tick),
        .stop_mode   (stop_mode),
        .stop_exit   (stop_exit),
        .ring_active (ring_active),
        .run         (run),
        .restart     (restart),
        .exit_hold   (exit_hold)
    );

    assign src_tick = ring_active ? ring_tick : hf_tick;

    cs_clk_div u_div (
        .clk     (clk),
        .srst_n  (srst_n),
        .run     (run),
        .hold    (stop_mode),
        .restart (restart),
        .tick    (src_tick),
        .code    (div_q),
        .clk_en  (clk_en)
    );

    assign sel_ring   = sel_q;
    assign div_code   = div_q;
    assign hf_osc_off = hf_off_q;

    a_r5_sel_survives_reset: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> $stable(sel_ring))
        else $error("select bit changed by system reset");

    a_r6_stop_silences: assert property (@(posedge clk) disable iff (!srst_n)
        stop_mode |-> !clk_en)
        else $error("enable pulse during stop mode");

    a_r7_exit_holds: assert property (@(posedge clk) disable iff (!srst_n)
        exit_hold |-> !clk_en)
        else $error("enable pulse during exit warmup");

    a_r10_pulse_on_tick: assert property (@(posedge clk) disable iff (!srst_n)
        clk_en |-> (ring_active ? ring_tick : hf_tick))
        else $error("enable pulse without a tick of the active source");

endmodule

// File: tb/clk_src_sel_test.sv
module clk_src_sel_test;

    localparam int HFW = 20;
    localparam int RGW = 10;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       hf_tick = 1'b0, ring_tick = 1'b0;
    logic       cfg_we = 1'b0, cfg_ring_sel = 1'b0, cfg_hf_off = 1'b0;
    logic [2:0] cfg_div = 3'd0;
    logic       stop_mode = 1'b0, stop_exit = 1'b0;
    logic       clk_en, ring_active, sel_ring, hf_osc_off;
    logic [2:0] div_code;

    int checks = 0;
    int errors = 0;
    int rphase = 0;

    always #4 clk = ~clk;

    clk_src_sel #(.HF_WARM_TICKS(HFW), .RING_WARM_TICKS(RGW)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .hf_tick(hf_tick),
        .ring_tick(ring_tick), .cfg_we(cfg_we), .cfg_ring_sel(cfg_ring_sel),
        .cfg_div(cfg_div), .cfg_hf_off(cfg_hf_off), .stop_mode(stop_mode),
        .stop_exit(stop_exit), .clk_en(clk_en), .ring_active(ring_active),
        .sel_ring(sel_ring), .div_code(div_code), .hf_osc_off(hf_osc_off)
    );

    // High-frequency tick every cycle, ring tick every third cycle.
    initial forever begin
        @(posedge clk);
        #1;
        rphase    = (rphase == 2) ? 0 : rphase + 1;
        ring_tick = (rphase == 0);
        hf_tick   = 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [2:0] dv, input logic off);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ring_sel = sel; cfg_div = dv; cfg_hf_off = off;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (clk_en) break;
        end
    endtask

    // Negedges from one pulse to the next.
    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en && n < 2000);
    endtask

    task automatic enter_stop();
        @(posedge clk); #1;
        stop_mode = 1'b1;
    endtask

    task automatic leave_stop();
        @(posedge clk); #1;
        stop_mode = 1'b0; stop_exit = 1'b1;
        @(posedge clk); #1;
        stop_exit = 1'b0;
    endtask

    // Count ticks of one source from the exit until the first pulse.
    task automatic ticks_to_pulse(input logic ring, output int n, output int st_bad);
        n = 0; st_bad = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (ring ? ring_tick : hf_tick) n++;
            if (ring_active != ring) st_bad = 1;
            if (clk_en) break;
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R5 sel after POR", int'(sel_ring), 0);
        chk("R5 ring_active after POR", int'(ring_active), 0);
        chk("R9 hf_osc_off after POR", int'(hf_osc_off), 0);
        chk("R1 div_code after POR", int'(div_code), 0);
        chk("R1 divide by 1 pulses every hf tick", int'(clk_en), 1);
    endtask

    task automatic t_divider_codes();
        int n;
        int exp [6] = '{1, 2, 4, 8, 256, 256};
        logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
        for (int k = 0; k < 6; k++) begin
            cfg_write(1'b0, codes[k], 1'b0);
            wait_pulse(); wait_pulse();
            gap(n);
            chk($sformatf("R1 period code %0d", codes[k]), n, exp[k]);
        end
    endtask

    task automatic t_divider_change();
        int n;
        cfg_write(1'b0, 3'd3, 1'b0);
        wait_pulse(); wait_pulse();
        wait_pulse();
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ring_sel = 1'b0; cfg_div = 3'd0; cfg_hf_off = 1'b0;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        n = 1;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en && n < 2000);
        chk("R2 old period completes after write", n, 8);
        @(negedge clk);
        chk("R2 new ratio after terminal count", int'(clk_en), 1);
    endtask

    task automatic t_osc_off();
        cfg_write(1'b0, 3'd0, 1'b1);
        @(negedge clk);
        chk("R9 hf_osc_off follows write", int'(hf_osc_off), 1);
        cfg_write(1'b0, 3'd0, 1'b0);
        @(negedge clk);
        chk("R9 hf_osc_off cleared by write", int'(hf_osc_off), 0);
    endtask

    task automatic t_to_ring();
        int n;
        cfg_write(1'b1, 3'd0, 1'b0);
        @(negedge clk);
        chk("R3 sel_ring set at write edge", int'(sel_ring), 1);
        chk("R3 ring_active not yet set", int'(ring_active), 0);
        @(negedge clk);
        chk("R3 ring_active set one edge later", int'(ring_active), 1);
        wait_pulse();
        chk("R10 pulse coincides with ring tick", int'(ring_tick), 1);
        gap(n);
        chk("R3 period follows ring ticks", n, 3);
    endtask

    task automatic t_to_hf();
        int n;
        cfg_write(1'b0, 3'd0, 1'b0);
        repeat (HFW) @(posedge clk);
        @(negedge clk);
        chk("R4 ring_active held through warmup", int'(ring_active), 1);
        @(negedge clk);
        chk("R4 ring_active falls after warmup", int'(ring_active), 0);
        wait_pulse(); gap(n);
        chk("R4 period follows hf ticks after switch", n, 1);
    endtask

    task automatic t_warm_reset();
        cfg_write(1'b1, 3'd3, 1'b1);
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R5 sel kept by system reset", int'(sel_ring), 1);
        chk("R5 ring_active kept by system reset", int'(ring_active), 1);
        chk("R5 div_code cleared by system reset", int'(div_code), 0);
        chk("R9 hf_osc_off cleared by system reset", int'(hf_osc_off), 0);
        @(posedge clk); #1; por_n = 1'b0;
        @(posedge clk); #1; por_n = 1'b1;
        @(negedge clk);
        chk("R5 sel cleared by POR", int'(sel_ring), 0);
        chk("R5 ring_active cleared by POR", int'(ring_active), 0);
    endtask

    task automatic t_stop_hf();
        int n, bad, seen;
        enter_stop();
        @(negedge clk);
        chk("R6 no pulse in stop entry cycle", int'(clk_en), 0);
        seen = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (clk_en) seen++;
        end
        chk("R6 no pulses while stopped", seen, 0);
        leave_stop();
        ticks_to_pulse(1'b0, n, bad);
        chk("R7 hf exit warmup length", n, HFW + 1);
        chk("R7 hf exit status stays 0", bad, 0);
    endtask

    task automatic t_stop_ring();
        int n, bad;
        cfg_write(1'b1, 3'd0, 1'b0);
        repeat (4) @(posedge clk);
        enter_stop();
        repeat (10) @(posedge clk);
        leave_stop();
        ticks_to_pulse(1'b1, n, bad);
        chk("R7 ring exit warmup length", n, RGW + 1);
        chk("R7 ring exit status stays 1", bad, 0);
    endtask

    task automatic t_stop_restart();
        int n, bad, seen;
        enter_stop();
        repeat (5) @(posedge clk);
        leave_stop();
        n = 0;
        while (n < 5) begin
            @(negedge clk);
            if (ring_tick) n++;
        end
        enter_stop();
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_en) seen++;
        end
        chk("R8 no pulses after re-entering stop", seen, 0);
        leave_stop();
        ticks_to_pulse(1'b1, n, bad);
        chk("R8 full ring warmup repeated", n, RGW + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1; por_n = 1'b1; rst_n = 1'b1;
        @(posedge clk);
        t_reset_state();
        t_divider_codes();
        t_divider_change();
        t_osc_off();
        t_to_ring();
        t_to_hf();
        t_warm_reset();
        t_stop_hf();
        t_stop_ring();
        t_stop_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule